// File: doc/BRIEF.md
# Sum Trailing-Zero Predictor

This block tells whether the low bits of a sum are all zero without forming the sum. It takes two operands of equal width, a carry-in bit and a bit index. A flag comes back that is high when bits zero through the index of `a + b + c` are all zero. Rounding logic for an adder uses this flag to decide whether a result is exact, so that the decision does not have to wait for the carry chain to settle.

The block builds a predicted word from bitwise operations only. With no carry-in, it takes the complement of `a ^ b` and XORs it with `(a | b)` shifted up one place. With a carry-in, it takes `a ^ b` and XORs it with `(a & b)` shifted up one place. It then complements the result. The low bits of this word are zero exactly when the same low bits of the sum are zero. Because of this, the flag has a fixed logic depth that does not grow with the operand width.

The block also reports a count of trailing zeros of the predicted word, limited to the operand width. This count equals the number of trailing zeros of the sum taken modulo 2^N. The block has no clock and holds no state.

Top module: `tzp_predictor`

## Requirements
- R1: With `cin`=0, `low_zero` is 1 exactly when bits [`idx`:0] of `opa + opb` are all zero.
- R2: With `cin`=1, `low_zero` is 1 exactly when bits [`idx`:0] of `opa + opb + 1` are all zero.
- R3: With `idx`=0, `low_zero` equals the complement of `opa[0] ^ opb[0] ^ cin`.
- R4: With `idx`=N-1, `low_zero` is 1 exactly when the sum modulo 2^N is zero; the carry out of bit N-1 has no effect.
- R5: Changing operand bits above position `idx` leaves `low_zero` unchanged.
- R6: `tz_count` equals the number of trailing zero bits of `(opa + opb + cin)` mod 2^N, and equals N when that value is zero.
- R7: `low_zero` is 1 exactly when `tz_count` is greater than `idx`.
- R8: Both outputs are combinational: they follow the inputs in the same cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | N | First addend |
| opb | input | N | Second addend |
| cin | input | 1 | Carry-in bit added to the sum |
| idx | input | $clog2(N) | Highest bit position included in the zero test |
| low_zero | output | 1 | High when sum bits [idx:0] are all zero |
| tz_count | output | $clog2(N+1) | Trailing-zero count of the predicted word, limited to N |

## Verification
The zero flag and the trailing-zero count both come from the same predicted word in the same evaluation. They are therefore checked together on each input set. Operands are built so that the sum has a chosen number of trailing zeros. This places the boundary right at, just below and just above `idx`, which exposes any off-by-one disagreement between the mask and the encoder. Each flag value and each count is judged against a reference that the bench takes from the true sum.

// File: rtl/tzp_pkg.sv
// Package for the trailing-zero predictor: the default operand width
// shared by the design, the checker and the bench.
package tzp_pkg;
    parameter int unsigned TZP_DEF_W = 32;
endpackage

// File: rtl/tzp_word_former.sv
// Builds the predicted word whose low bits are zero exactly when the
// same low bits of opa + opb + cin are zero.
// Assumes cin is a single bit; fixed logic depth, independent of N.
module tzp_word_former #(
    parameter int unsigned N = tzp_pkg::TZP_DEF_W
) (
    input  logic [N-1:0] opa,
    input  logic [N-1:0] opb,
    input  logic         cin,
    output logic [N:0]   pred
);
    logic [N-1:0] half_sum;
    logic [N-1:0] first_w;
    logic [N:0]   second_w;

    assign half_sum = opa ^ opb;

    // Select the word pair for the carry-in value.
    always_comb begin
        if (cin) begin
            first_w  = half_sum;
            second_w = {opa & opb, 1'b0};
        end else begin
            first_w  = ~half_sum;
            second_w = {opa | opb, 1'b0};
        end
    end

    // Predicted word: complement of the XOR of the two words over N+1 bits.
    assign pred = ~({1'b0, first_w} ^ second_w);
endmodule

// File: rtl/tzp_mask_gen.sv
// Turns the bit index into a mask whose bits [idx:0] are set.
// Assumes idx < N; a larger idx sets every bit.
module tzp_mask_gen #(
    parameter int unsigned N  = tzp_pkg::TZP_DEF_W,
    parameter int unsigned KW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [KW-1:0] idx,
    output logic [N-1:0]  mask
);
    // One comparator for each mask bit.
    for (genvar i = 0; i < N; i++) begin : g_bit
        assign mask[i] = ({1'b0, idx} >= (KW+1)'(i));
    end
endmodule

// File: rtl/tzp_tz_count.sv
// Counts the trailing zeros of a vector, limited to N when the vector is zero.
// Isolates the lowest set bit, then encodes its position.
module tzp_tz_count #(
    parameter int unsigned N  = tzp_pkg::TZP_DEF_W,
    parameter int unsigned CW = $clog2(N + 1)
) (
    input  logic [N-1:0]  vec,
    output logic [CW-1:0] count
);
    logic [N-1:0] lowest;

    assign lowest = vec & (~vec + N'(1));

    // Encode the position of the one-hot lowest bit; all-zero maps to N.
    always_comb begin
        count = '0;
        for (int i = 0; i < N; i++) begin
            if (lowest[i]) count = count | CW'(i);
        end
        if (vec == '0) count = CW'(N);
    end
endmodule

// File: rtl/tzp_predictor.sv
// Top level: zero flag for sum bits [idx:0] and a trailing-zero count,
// both taken from the predicted word, with no carry chain. Purely combinational.
module tzp_predictor #(
    parameter int unsigned N  = tzp_pkg::TZP_DEF_W,
    parameter int unsigned KW = (N > 1) ? $clog2(N) : 1,
    parameter int unsigned CW = $clog2(N + 1)
) (
    input  logic [N-1:0]  opa,
    input  logic [N-1:0]  opb,
    input  logic          cin,
    input  logic [KW-1:0] idx,
    output logic          low_zero,
    output logic [CW-1:0] tz_count
);
    logic [N:0]   pred;
    logic [N-1:0] mask;

    tzp_word_former #(.N(N)) u_form (
        .opa (opa),
        .opb (opb),
        .cin (cin),
        .pred(pred)
    );

    tzp_mask_gen #(.N(N), .KW(KW)) u_mask (
        .idx (idx),
        .mask(mask)
    );

    tzp_tz_count #(.N(N), .CW(CW)) u_cnt (
        .vec  (pred[N-1:0]),
        .count(tz_count)
    );

    // NOR of the masked low bits of the predicted word.
    assign low_zero = ~|(pred[N-1:0] & mask);
endmodule

// File: rtl/tzp_checker.sv
// Checker for tzp_predictor: relates the flag, the count and the ports.
// Immediate assertions, because the block has no clock.
module tzp_checker #(
    parameter int unsigned N  = tzp_pkg::TZP_DEF_W,
    parameter int unsigned KW = (N > 1) ? $clog2(N) : 1,
    parameter int unsigned CW = $clog2(N + 1)
) (
    input logic [N-1:0]  opa,
    input logic [N-1:0]  opb,
    input logic          cin,
    input logic [KW-1:0] idx,
    input logic          low_zero,
    input logic [CW-1:0] tz_count
);
    // Check the flag and the count against each other and against the ports.
    always_comb begin
        a_r7_flag_matches_count: assert (low_zero == ({1'b0, tz_count} > (CW+1)'(idx)));
        if (idx == '0) begin
            a_r3_bit0_parity: assert (low_zero == ~(opa[0] ^ opb[0] ^ cin));
        end
        a_r6_count_bounded: assert (tz_count <= CW'(N));
        if (tz_count == CW'(N)) begin
            a_r4_all_zero_sets_flag: assert (low_zero);
        end
    end
endmodule

bind tzp_predictor tzp_checker #(.N(N), .KW(KW), .CW(CW)) u_chk (
    .opa     (opa),
    .opb     (opb),
    .cin     (cin),
    .idx     (idx),
    .low_zero(low_zero),
    .tz_count(tz_count)
);

// File: tb/tzp_predictor_tb.sv
// Bench for tzp_predictor: directed corners plus seeded random operands,
// judged against the true sum.
module tzp_predictor_tb;
    localparam int unsigned N  = tzp_pkg::TZP_DEF_W;
    localparam int unsigned KW = (N > 1) ? $clog2(N) : 1;
    localparam int unsigned CW = $clog2(N + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  opa = '0;
    logic [N-1:0]  opb = '0;
    logic          cin = 1'b0;
    logic [KW-1:0] idx = '0;
    logic          low_zero;
    logic [CW-1:0] tz_count;
    int            n_cmp = 0;
    int            n_bad = 0;
    bit            done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    tzp_predictor #(.N(N)) u_dut (
        .opa(opa), .opb(opb), .cin(cin), .idx(idx),
        .low_zero(low_zero), .tz_count(tz_count)
    );

    function automatic logic [N-1:0] ref_sum(logic [N-1:0] x, logic [N-1:0] y, logic c);
        return x + y + N'(c);
    endfunction

    function automatic logic ref_flag(logic [N-1:0] s, int k);
        for (int i = 0; i <= k; i++) if (s[i]) return 1'b0;
        return 1'b1;
    endfunction

    function automatic int ref_tz(logic [N-1:0] s);
        for (int i = 0; i < N; i++) if (s[i]) return i;
        return N;
    endfunction

    // Drive one input set at the falling edge and compare both outputs.
    task automatic apply(logic [N-1:0] x, logic [N-1:0] y, logic c, int k, string tag);
        logic [N-1:0] s;
        @(negedge clk);
        opa = x; opb = y; cin = c; idx = KW'(k);
        #1;
        s = ref_sum(x, y, c);
        n_cmp++;
        if (low_zero !== ref_flag(s, k)) begin
            n_bad++;
            $display("FAIL %s flag k=%0d: got %0b expected %0b", tag, k, low_zero, ref_flag(s, k));
        end
        n_cmp++;
        if (int'(tz_count) != ref_tz(s)) begin
            n_bad++;
            $display("FAIL R6 count: got %0d expected %0d", tz_count, ref_tz(s));
        end
    endtask

    initial begin
        logic [N-1:0] x;
        logic [N-1:0] y;
        logic         c;
        logic         f0;
        void'($urandom(32'd1234));
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        // Reset-state check: all-zero inputs give a zero sum (R8).
        #1;
        n_cmp++;
        if (low_zero !== 1'b1 || int'(tz_count) != N) begin
            n_bad++;
            $display("FAIL R8 idle: got %0b/%0d expected 1/%0d", low_zero, tz_count, N);
        end
        // Directed corners.
        apply('1, N'(1), 1'b0, N-1, "R4");   // carry out dropped, sum zero
        apply('1, '0, 1'b1, N-1, "R4");
        apply('1, '1, 1'b1, N-1, "R4");
        apply(N'(1), '0, 1'b0, 0, "R3");
        apply(N'(1), '0, 1'b1, 0, "R3");
        apply('0, '0, 1'b1, 0, "R3");
        apply(N'(4), N'(4), 1'b0, 3, "R1");   // sum 8: zero through bit 2 and 3? bit3 set
        apply(N'(4), N'(4), 1'b0, 2, "R1");
        // Random operands with a planted trailing-zero run.
        for (int k = 0; k < N; k++) begin
            for (int r = 0; r < 40; r++) begin
                int sh;
                c  = 1'($urandom);
                x  = N'({$urandom, $urandom});
                sh = $urandom_range(0, N);
                y  = (sh >= N) ? N'(0) : (N'({$urandom, $urandom}) << sh);
                y  = y - x - N'(c);
                if (r % 5 == 0) y = N'({$urandom, $urandom});
                apply(x, y, c, k, (k == N-1) ? "R4" : (k == 0) ? "R3" : (c ? "R2" : "R1"));
            end
        end
        // R5: bits above idx do not affect the flag.
        for (int r = 0; r < 60; r++) begin
            int k;
            logic [N-1:0] hi;
            k  = $urandom_range(0, N-2);
            c  = 1'($urandom);
            x  = N'({$urandom, $urandom});
            y  = (N'({$urandom, $urandom}) << (k + 1 - (r % 3))) - x - N'(c);
            apply(x, y, c, k, "R5");
            f0 = low_zero;
            hi = N'({$urandom, $urandom}) << (k + 1);
            @(negedge clk);
            opa = x ^ hi;
            opb = y ^ (hi >> 1 << 1);
            #1;
            n_cmp++;
            if (low_zero !== f0) begin
                n_bad++;
                $display("FAIL R5 k=%0d: got %0b expected %0b", k, low_zero, f0);
            end
        end
        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_cmp++;
                n_bad++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule